// File: doc/BRIEF.md
# Shared Memory Bank Conflict Serializer

This block sits in front of a banked on-chip scratch memory and turns one warp-wide access into a sequence of conflict-free passes. A request carries one word address per lane, a mask of participating lanes and a select for 32-bit or 64-bit elements. Every word touched by the request is assigned a bank, and the block then issues passes. In each pass, a bank delivers no more than one distinct word. The output of each pass is a mask of the lanes served in it.

In 64-bit mode each lane touches two words: one on an even bank and one on the odd bank just above it. Lanes that name the same word are served together, as a broadcast. The number of passes equals the largest count of distinct words that share a bank. That number is reported once the block goes idle, so the caller learns how far the access was slowed.

Top module: `bcs_serializer`

## Requirements
- R1: A word address maps to bank `addr mod 32`, which is its five least significant bits. Lanes whose banks all differ never wait on one another.
- R2: After `start` is accepted while idle, `busy` rises on the next cycle. It stays high for exactly N cycles, where N is the largest number of distinct words mapped to one bank. Once `busy` is low, `replay_count` equals N.
- R3: When all 32 active lanes fall on 32 different banks, the access takes one pass and every active lane is granted in that pass.
- R4: Lanes that name the same word address are granted in the same pass and do not count as a conflict. A request in which all lanes name one word completes in one pass.
- R5: If 32 lanes name 32 distinct words in one bank, the access takes 32 passes and grants one lane per pass, in ascending lane order.
- R6: When `elem_wide`=1, bit 0 of a lane address is ignored. The lane's low word is the address with bit 0 cleared, which lies on an even bank, and its high word is that address plus one. A lane is shown in `lane_grant` in every pass in which either of its words is delivered.
- R7: In 64-bit mode, lanes holding consecutive elements (lane i at address 2i) cause a two-way conflict and take 2 passes.
- R8: In each pass, every bank serves the word of its lowest-numbered pending lane, with the low word ahead of the high word. All pending lanes naming that same word are served with it.
- R9: Inactive lanes are never granted. If the active mask is empty, `busy` stays low and `replay_count` becomes 0.
- R10: A `start` that arrives while `busy` is high is ignored and does not change the passes still to come.
- R11: After reset, `busy` is 0, `lane_grant` is 0 and `replay_count` is 0.
- R12: `lane_grant` is zero whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request valid; taken only while idle |
| elem_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| lane_addr | input | LANES*ADDR_W | Word address per lane; lane i at bits [i*ADDR_W +: ADDR_W] |
| lane_active | input | LANES | Participating lanes |
| busy | output | 1 | High for each replay pass |
| lane_grant | output | LANES | Lanes served in the current pass |
| replay_count | output | CNT_W | Number of passes of the last request |

## Verification
The bench runs several directed patterns. A unit-stride pattern checks the bank mapping. A pattern in which every lane names one word checks the broadcast merging. A stride of 32 puts every lane on one bank and gives the worst case along with the grant order. In 64-bit mode, consecutive addresses with bit 0 both clear and set check the even/odd word split and confirm that bit 0 is ignored. Empty and sparse masks check the exclusion of inactive lanes, and a restart during a replay checks that `start` is ignored while busy. Random addresses drawn from a narrow range give mixed conflict depths, each compared every cycle with a model that orders each bank's distinct words by first appearance.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        ELEM_32 = 1'b0,
        ELEM_64 = 1'b1
    } elem_mode_e;

    localparam int DEF_LANES  = 32;
    localparam int DEF_BANKS  = 32;
    localparam int DEF_ADDR_W = 16;

    // Number of word slots a lane may occupy (low and high half)
    localparam int SLOTS_PER_LANE = 2;

    function automatic int slot_index(input int lane, input int half);
        return lane * SLOTS_PER_LANE + half;
    endfunction

endpackage

// File: rtl/bcs_word_expand.sv
module bcs_word_expand
    import bcs_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int WORDS = LANES * SLOTS_PER_LANE
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  elem_mode_e              mode,
    output logic [ADDR_W-1:0]       word_addr [WORDS]
);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            logic [ADDR_W-1:0] base;
            base = addr_flat[l*ADDR_W +: ADDR_W];
            if (mode == ELEM_64) begin
                word_addr[slot_index(l, 0)] = {base[ADDR_W-1:1], 1'b0};
                word_addr[slot_index(l, 1)] = {base[ADDR_W-1:1], 1'b1};
            end else begin
                word_addr[slot_index(l, 0)] = base;
                word_addr[slot_index(l, 1)] = base;
            end
        end
    end

endmodule

// File: rtl/bcs_bank_pick.sv
module bcs_bank_pick
    import bcs_pkg::*;
#(
    parameter int WORDS  = DEF_LANES * SLOTS_PER_LANE,
    parameter int BANKS  = DEF_BANKS,
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [ADDR_W-1:0] word_addr [WORDS],
    input  logic [WORDS-1:0]  pending,
    output logic [WORDS-1:0]  word_grant
);

    logic [ADDR_W-1:0] chosen_addr [BANKS];
    logic [BANKS-1:0]  bank_has;

    // Per bank: address of the lowest-indexed pending word
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            logic found;
            logic [ADDR_W-1:0] pick;
            found = 1'b0;
            pick  = '0;
            for (int j = 0; j < WORDS; j++) begin
                if (!found && pending[j] &&
                    word_addr[j][BANK_W-1:0] == BANK_W'(b)) begin
                    found = 1'b1;
                    pick  = word_addr[j];
                end
            end
            chosen_addr[b] = pick;
            bank_has[b]    = found;
        end
    end

    // Every pending word equal to its bank's chosen word is served
    always_comb begin
        for (int j = 0; j < WORDS; j++) begin
            logic [BANK_W-1:0] bk;
            bk = word_addr[j][BANK_W-1:0];
            word_grant[j] = pending[j] && bank_has[bk] &&
                            (word_addr[j] == chosen_addr[bk]);
        end
    end

endmodule

// File: rtl/bcs_lane_fold.sv
module bcs_lane_fold
    import bcs_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    localparam int WORDS = LANES * SLOTS_PER_LANE
) (
    input  logic [WORDS-1:0] word_grant,
    output logic [LANES-1:0] lane_hit
);

    for (genvar l = 0; l < LANES; l++) begin : g_fold
        assign lane_hit[l] = |word_grant[l*SLOTS_PER_LANE +: SLOTS_PER_LANE];
    end

endmodule

// File: rtl/bcs_serializer.sv
module bcs_serializer
    import bcs_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int BANKS  = DEF_BANKS,
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int WORDS = LANES * SLOTS_PER_LANE,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    elem_wide,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        lane_active,
    output logic                    busy,
    output logic [LANES-1:0]        lane_grant,
    output logic [CNT_W-1:0]        replay_count
);

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        act_q;
    elem_mode_e              mode_q;
    logic [WORDS-1:0]        pending_q;
    logic                    busy_q;
    logic [CNT_W-1:0]        cnt_q;

    logic [ADDR_W-1:0]       word_addr [WORDS];
    logic [WORDS-1:0]        word_grant;
    logic [LANES-1:0]        lane_hit;
    logic [WORDS-1:0]        load_mask;
    logic [WORDS-1:0]        pending_nx;
    logic                    accept;

    assign accept     = start && !busy_q;
    assign pending_nx = pending_q & ~word_grant;

    // Word slots a fresh request occupies
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            load_mask[slot_index(l, 0)] = lane_active[l];
            load_mask[slot_index(l, 1)] = lane_active[l] & elem_wide;
        end
    end

    bcs_word_expand #(.LANES(LANES), .ADDR_W(ADDR_W)) u_expand (
        .addr_flat (addr_q),
        .mode      (mode_q),
        .word_addr (word_addr)
    );

    bcs_bank_pick #(.WORDS(WORDS), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_pick (
        .word_addr  (word_addr),
        .pending    (pending_q),
        .word_grant (word_grant)
    );

    bcs_lane_fold #(.LANES(LANES)) u_fold (
        .word_grant (word_grant),
        .lane_hit   (lane_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            act_q     <= '0;
            mode_q    <= ELEM_32;
            pending_q <= '0;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
        end else if (busy_q) begin
            pending_q <= pending_nx;
            cnt_q     <= cnt_q + 1'b1;
            busy_q    <= |pending_nx;
        end else if (accept) begin
            addr_q    <= lane_addr;
            act_q     <= lane_active;
            mode_q    <= elem_wide ? ELEM_64 : ELEM_32;
            pending_q <= load_mask;
            busy_q    <= |lane_active;
            cnt_q     <= '0;
        end
    end

    assign busy         = busy_q;
    assign lane_grant   = busy_q ? lane_hit : '0;
    assign replay_count = cnt_q;

    initial begin
        if ((1 << $clog2(BANKS)) != BANKS) $error("BANKS must be a power of two");
        if (ADDR_W <= $clog2(BANKS)) $error("ADDR_W too narrow");
    end

    AST_GRANT_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((lane_grant & ~act_q) == '0));                     // R9
    AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lane_grant != '0));                                // R2
    AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> ((pending_q & ~$past(pending_q)) == '0));         // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> ($stable(addr_q) && $stable(act_q)));  // R10
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        replay_count <= CNT_W'(LANES));                              // R5

endmodule

// File: tb/bcs_serializer_tb_top.sv
module bcs_serializer_tb_top;

    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = $clog2(LANES + 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic                    elem_wide = 1'b0;
    logic [LANES*ADDR_W-1:0] lane_addr;
    logic [LANES-1:0]        lane_active = '0;
    logic                    busy;
    logic [LANES-1:0]        lane_grant;
    logic [CNT_W-1:0]        replay_count;

    logic [ADDR_W-1:0] addr_arr [LANES];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int l = 0; l < LANES; l++) lane_addr[l*ADDR_W +: ADDR_W] = addr_arr[l];
    end

    bcs_serializer #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .elem_wide(elem_wide),
        .lane_addr(lane_addr), .lane_active(lane_active),
        .busy(busy), .lane_grant(lane_grant), .replay_count(replay_count)
    );

    // ---------------- reference model ----------------
    logic [LANES-1:0] m_q [$];
    int               m_cnt = 0;

    // Distinct words per bank in order of first appearance; a lane's
    // pass is the position of its word in its bank's list.
    function automatic void build_sched(output int npass,
                                        output logic [LANES-1:0] sm [2*LANES]);
        int dn [BANKS];
        int da [BANKS][2*LANES];
        npass = 0;
        for (int b = 0; b < BANKS; b++) dn[b] = 0;
        for (int p = 0; p < 2*LANES; p++) sm[p] = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int h = 0; h < 2; h++) begin
                int w, b, k;
                if (!lane_active[l]) continue;
                if (!elem_wide && h == 1) continue;
                w = elem_wide ? ((int'(addr_arr[l]) & ~1) + h) : int'(addr_arr[l]);
                b = w % BANKS;
                k = -1;
                for (int i = 0; i < dn[b]; i++) if (da[b][i] == w) k = i;
                if (k < 0) begin
                    k = dn[b];
                    da[b][k] = w;
                    dn[b]++;
                end
                sm[k][l] = 1'b1;
                if (k + 1 > npass) npass = k + 1;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_cnt = 0;
        end else if (m_q.size() > 0) begin
            void'(m_q.pop_front());
        end else if (start) begin
            int np;
            logic [LANES-1:0] sm [2*LANES];
            build_sched(np, sm);
            for (int p = 0; p < np; p++) m_q.push_back(sm[p]);
            m_cnt = np;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the clock edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            logic             e_busy;
            logic [LANES-1:0] e_grant;
            e_busy  = (m_q.size() > 0);
            e_grant = e_busy ? m_q[0] : '0;
            check("R2 busy", 64'(busy), 64'(e_busy));
            check("R8 lane_grant", 64'(lane_grant), 64'(e_grant));
            if (!e_busy) check("R2 replay_count", 64'(replay_count), 64'(m_cnt));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (!busy && m_q.size() == 0) break;
            @(negedge clk);
        end
    endtask

    task automatic run_req(input logic wide, input logic [LANES-1:0] mask);
        elem_wide   = wide;
        lane_active = mask;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) addr_arr[l] = '0;
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11 busy", 64'(busy), 64'd0);
        check("R11 lane_grant", 64'(lane_grant), 64'd0);
        check("R11 replay_count", 64'(replay_count), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1, R3: unit stride, all banks distinct
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l + 64);
        run_req(1'b0, '1);
        check("R3 one pass", 64'(replay_count), 64'd1);

        // R1: addresses differing above bit 4 still hit distinct banks
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l * 33);
        run_req(1'b0, '1);
        check("R1 mod-32 banks", 64'(replay_count), 64'd1);

        // R4: broadcast of one word
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(5);
        run_req(1'b0, '1);
        check("R4 broadcast", 64'(replay_count), 64'd1);

        // R5, R8: every lane on bank 0, distinct words
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l * 32);
        elem_wide = 1'b0; lane_active = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 first pass lowest lane", 64'(lane_grant), 64'd1);
        @(negedge clk);
        check("R5 second pass lane1", 64'(lane_grant), 64'd2);
        wait_idle();
        check("R5 worst case 32", 64'(replay_count), 64'd32);

        // R7: 64-bit consecutive elements
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(2 * l);
        run_req(1'b1, '1);
        check("R7 two-way", 64'(replay_count), 64'd2);

        // R6: bit 0 ignored in 64-bit mode
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(2 * l + 1);
        run_req(1'b1, '1);
        check("R6 odd bit ignored", 64'(replay_count), 64'd2);

        // R6: 64-bit half-wide set of lanes fits in one pass
        run_req(1'b1, 32'h0000_FFFF);
        check("R6 16 lanes one pass", 64'(replay_count), 64'd1);

        // R9: empty mask
        run_req(1'b0, '0);
        check("R9 empty busy", 64'(busy), 64'd0);
        check("R9 empty count", 64'(replay_count), 64'd0);

        // R9: sparse mask on a conflicting set
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l * 32 + 3);
        run_req(1'b0, 32'h0000_0055);
        check("R9 sparse count", 64'(replay_count), 64'd4);

        // R10: start during replay is ignored
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l * 64);
        elem_wide = 1'b0; lane_active = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'(l);
        lane_active = 32'h0000_0003;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_idle();
        check("R10 restart ignored", 64'(replay_count), 64'd32);

        // R12: idle grants zero
        check("R12 idle grant", 64'(lane_grant), 64'd0);

        // R2: random mixed conflicts, checked by model each cycle
        for (int t = 0; t < 40; t++) begin
            for (int l = 0; l < LANES; l++) addr_arr[l] = ADDR_W'($urandom_range(0, 255));
            run_req(1'($urandom_range(0, 1)), $urandom());
        end

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule